// File: doc/BRIEF.md
# Switch-Set Duty PWM Generator with Button-Selected Tick Rate

This block produces a pulse-width-modulated output with a fixed period. A programmable divider makes a square-wave tick from the master clock. Its rate comes from one of three presets, and a push button picks the preset. Each rising edge of the tick advances a 5-bit wrapping counter, which is also shown on LEDs. The output is high while that counter is at or above a duty threshold. Four slide switches set the threshold in 16 even steps across the 32-count period.

The master clock is 50 MHz. The three presets are terminal counts of 4999999, 4999 and 49, which give tick rates of 5 Hz, 5 kHz and 500 kHz. The divider toggles its tick each time its count passes the terminal value, so the tick is a square wave with 50% duty. The fourth button is the reset. After reset the divider is stopped until a rate button is pressed. A 2-bit code output tells a display controller which rate is selected.

Top module: `pwm_rate_gen`

## Requirements
- R1: While button 3 is held (after two-flop synchronization), the freq code is 0, the divided clock is low, the LED counter is 0 and the PWM output is low.
- R2: With freq code 0 (stopped), the divided clock and the LED counter do not change.
- R3: Pressing button 0 sets freq code 1, and the divided clock period becomes 2*(TC_SLOW+1) master cycles.
- R4: Pressing button 1 sets freq code 2, and the divided clock period becomes 2*(TC_MID+1) master cycles.
- R5: Pressing button 2 sets freq code 3, and the divided clock period becomes 2*(TC_FAST+1) master cycles.
- R6: The last selection is held after the buttons are released, until reset or another press. When several rate buttons are held together, the lowest-numbered one wins.
- R7: A change of selection restarts the divide count from zero. The first tick toggle then comes TC+2 master cycles after the new freq code appears.
- R8: The LED counter rises by exactly one, wrapping 31 to 0, on each rising edge of the divided clock, and holds at all other times.
- R9: The threshold is the 4-bit switch value shifted left by one (switch value times 2). The PWM output is high when the counter is greater than or equal to that threshold, one master cycle after the counter value. Over one counter period it is therefore high for (32 - 2*switch) tick periods: always high for switch 0, and high for 2 of 32 ticks for switch 15.
- R10: The PWM period is 32 divided-clock periods, whatever the switch setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| btn_i | input | 4 | Push buttons, active high: bit 0 slow, bit 1 mid, bit 2 fast, bit 3 reset |
| sw_i | input | 4 | Slide switches that set the duty threshold |
| pwm_o | output | 1 | PWM output (registered) |
| div_clk_o | output | 1 | Divided square-wave tick |
| led_o | output | 5 | Counter value for the LEDs |
| freq_code_o | output | 2 | 0 stopped, 1 slow, 2 mid, 3 fast |

## Verification
The bench targets five corner cases.
- Switch values 0 and 15, the extremes of the duty range. A comparison that is off by one or uses strict "greater than" gives a wrong high-time count over a full counter period.
- Pressing a rate button in the middle of a slow count. A divider that does not clear would carry its old count, and the first toggle would come late or early.
- Pressing several buttons at once. A wrong priority shows up as the wrong freq code.
- The counter wrap from 31 to 0.
- The idle state after reset. A divider that runs while stopped shows edges on the tick output or the LEDs.

// File: rtl/pwm_rate_pkg.sv
package pwm_rate_pkg;
  typedef enum logic [1:0] {
    FREQ_STOP = 2'd0,
    FREQ_SLOW = 2'd1,
    FREQ_MID  = 2'd2,
    FREQ_FAST = 2'd3
  } freq_e;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    meta_q <= d_i;
    q_o    <= meta_q;
  end
endmodule

// File: rtl/pwm_rate_sel.sv
module pwm_rate_sel
  import pwm_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] press_i,
  output freq_e      code_o
);
  always_ff @(posedge clk) begin
    if (rst)             code_o <= FREQ_STOP;
    else if (press_i[0]) code_o <= FREQ_SLOW;
    else if (press_i[1]) code_o <= FREQ_MID;
    else if (press_i[2]) code_o <= FREQ_FAST;
  end

  // R6: the selection holds while no rate button is pressed
  assert_hold_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (press_i == 3'b000) |=> $stable(code_o));
endmodule

// File: rtl/pwm_clk_div.sv
module pwm_clk_div
  import pwm_rate_pkg::*;
#(
  parameter int          TC_W    = 23,
  parameter int unsigned TC_SLOW = 4999999,
  parameter int unsigned TC_MID  = 4999,
  parameter int unsigned TC_FAST = 49
) (
  input  logic  clk,
  input  logic  rst,
  input  freq_e code_i,
  output logic  tick_o
);
  logic [TC_W-1:0] dcnt_q;
  logic [TC_W-1:0] tc_cur;
  freq_e           prev_q;
  logic            chg;

  always_comb begin
    case (code_i)
      FREQ_SLOW: tc_cur = TC_W'(TC_SLOW);
      FREQ_MID:  tc_cur = TC_W'(TC_MID);
      FREQ_FAST: tc_cur = TC_W'(TC_FAST);
      default:   tc_cur = '0;
    endcase
  end

  assign chg = (code_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q <= '0;
      tick_o <= 1'b0;
      prev_q <= FREQ_STOP;
    end else begin
      prev_q <= code_i;
      if (chg || code_i == FREQ_STOP) begin
        dcnt_q <= '0;
      end else if (dcnt_q == tc_cur) begin
        dcnt_q <= '0;
        tick_o <= ~tick_o;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  // R2: a stopped divider never moves its tick
  assert_stop_still_R2: assert property (@(posedge clk) disable iff (rst)
    (code_i == FREQ_STOP) |=> $stable(tick_o));

  // R7: with a settled selection the count never passes the terminal value
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (code_i == prev_q) |-> (dcnt_q <= tc_cur));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 5,
  parameter int SW_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [SW_W-1:0]  sw_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  localparam int               SHIFT   = CNT_W - SW_W;
  localparam logic [CNT_W-1:0] THR_DEF = CNT_W'(1) << (CNT_W - 1);

  logic             tick_d;
  logic             rise;
  logic [CNT_W-1:0] thr_q;

  assign rise = tick_i & ~tick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d <= 1'b0;
      cnt_o  <= '0;
      thr_q  <= THR_DEF;
      pwm_o  <= 1'b0;
    end else begin
      tick_d <= tick_i;
      thr_q  <= CNT_W'(sw_i) << SHIFT;
      pwm_o  <= (cnt_o >= thr_q);
      if (rise) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R8: one step per tick rise, wrapping naturally
  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R8: no movement between tick rises
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen
  import pwm_rate_pkg::*;
#(
  parameter int          TC_W    = 23,
  parameter int unsigned TC_SLOW = 4999999,
  parameter int unsigned TC_MID  = 4999,
  parameter int unsigned TC_FAST = 49,
  parameter int          CNT_W   = 5,
  parameter int          SW_W    = 4
) (
  input  logic             clk,
  input  logic [3:0]       btn_i,
  input  logic [SW_W-1:0]  sw_i,
  output logic             pwm_o,
  output logic             div_clk_o,
  output logic [CNT_W-1:0] led_o,
  output logic [1:0]       freq_code_o
);
  localparam int SYNC_W = SW_W + 4;

  logic [SYNC_W-1:0] sync_q;
  logic              rst_s;
  freq_e             code;

  pwm_sync #(.W(SYNC_W)) sync_i (
    .clk (clk),
    .d_i ({sw_i, btn_i}),
    .q_o (sync_q)
  );

  assign rst_s = sync_q[3];

  pwm_rate_sel sel_i (
    .clk     (clk),
    .rst     (rst_s),
    .press_i (sync_q[2:0]),
    .code_o  (code)
  );

  pwm_clk_div #(
    .TC_W(TC_W), .TC_SLOW(TC_SLOW), .TC_MID(TC_MID), .TC_FAST(TC_FAST)
  ) div_i (
    .clk    (clk),
    .rst    (rst_s),
    .code_i (code),
    .tick_o (div_clk_o)
  );

  pwm_core #(.CNT_W(CNT_W), .SW_W(SW_W)) core_i (
    .clk    (clk),
    .rst    (rst_s),
    .tick_i (div_clk_o),
    .sw_i   (sync_q[SYNC_W-1:4]),
    .cnt_o  (led_o),
    .pwm_o  (pwm_o)
  );

  assign freq_code_o = code;

  // R1: reset forces the stopped code on the next edge
  assert_reset_code_R1: assert property (@(posedge clk)
    rst_s |=> (freq_code_o == 2'd0));
endmodule

// File: tb/pwm_rate_gen_tb_top.sv
module pwm_rate_gen_tb_top;
  localparam int TS = 199, TM = 19, TF = 3;
  localparam int VEC_SW[6] = '{0, 1, 5, 8, 12, 15};
  localparam int VEC_HI[6] = '{256, 240, 176, 128, 64, 16};

  logic       clk = 1'b0;
  logic [3:0] btn = 4'b1000;
  logic [3:0] sw  = 4'd0;
  logic       pwm, dclk;
  logic [4:0] led;
  logic [1:0] code;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pwm_rate_gen #(.TC_W(23), .TC_SLOW(TS), .TC_MID(TM), .TC_FAST(TF)) dut_i (
    .clk(clk), .btn_i(btn), .sw_i(sw), .pwm_o(pwm),
    .div_clk_o(dclk), .led_o(led), .freq_code_o(code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] b);
    btn = b;
    repeat (5) @(negedge clk);
    btn = 4'b0000;
    repeat (6) @(negedge clk);
  endtask

  task automatic measure_period(output int per);
    per = 0;
    while (dclk !== 1'b0) @(negedge clk);
    while (dclk !== 1'b1) @(negedge clk);
    @(negedge clk); per = 1;
    while (dclk !== 1'b0) begin @(negedge clk); per++; end
    while (dclk !== 1'b1) begin @(negedge clk); per++; end
  endtask

  initial begin
    int per, n, hi, errs, changes;
    logic lv;
    logic [4:0] prev;

    repeat (10) @(negedge clk);
    chk(code == 2'd0, "R1 code", code, 0);
    chk(dclk == 1'b0 && led == 5'd0, "R1 div/led", {dclk, led}, 0);
    chk(pwm == 1'b0, "R1 pwm", pwm, 0);

    btn = 4'b0000;
    changes = 0;
    repeat (100) begin
      @(negedge clk);
      if (dclk !== 1'b0 || led !== 5'd0) changes++;
    end
    chk(changes == 0 && code == 2'd0, "R2 stopped", changes, 0);

    press(4'b0100);
    chk(code == 2'd3, "R5 code", code, 3);
    chk(code == 2'd3, "R6 held after release", code, 3);
    measure_period(per);
    chk(per == 2 * (TF + 1), "R5 period", per, 2 * (TF + 1));

    for (int i = 0; i < 6; i++) begin
      sw = VEC_SW[i][3:0];
      repeat (300) @(negedge clk);
      hi = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (pwm) hi++;
      end
      chk(hi == VEC_HI[i], "R9/R10 duty", hi, VEC_HI[i]);
    end

    errs = 0; n = 0; prev = led;
    while (n < 70) begin
      @(negedge clk);
      if (led != prev) begin
        if (led != prev + 5'd1) errs++;
        prev = led; n++;
      end
    end
    chk(errs == 0, "R8 step and wrap", errs, 0);

    press(4'b0010);
    chk(code == 2'd2, "R4 code", code, 2);
    measure_period(per);
    chk(per == 2 * (TM + 1), "R4 period", per, 2 * (TM + 1));

    press(4'b0001);
    chk(code == 2'd1, "R3 code", code, 1);
    measure_period(per);
    chk(per == 2 * (TS + 1), "R3 period", per, 2 * (TS + 1));

    while (dclk !== 1'b0) @(negedge clk);
    while (dclk !== 1'b1) @(negedge clk);
    repeat (50) @(negedge clk);
    btn = 4'b0100;
    while (code != 2'd3) @(negedge clk);
    btn = 4'b0000;
    lv = dclk; n = 0;
    while (dclk == lv && n < 1000) begin @(negedge clk); n++; end
    chk(n == TF + 2, "R7 restart", n, TF + 2);

    press(4'b0111);
    chk(code == 2'd1, "R6 priority", code, 1);
    repeat (20) @(negedge clk);
    chk(code == 2'd1, "R6 held", code, 1);

    btn = 4'b1000;
    repeat (4) @(negedge clk);
    chk(code == 2'd0 && dclk == 1'b0 && led == 5'd0 && pwm == 1'b0,
        "R1 mid-run reset", {code, dclk, led, pwm}, 0);
    btn = 4'b0000;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule